// File: doc/BRIEF.md
# Pin Bank with Shared Debounce Timers

This block is a bank of general-purpose pins controlled through a simple single-cycle register bus. Every pin owns one control word. The word holds the output level and the drive enable, and it sets how the pin is sampled and how it raises interrupts. Each input passes through a two-stage synchronizer. It then passes through a glitch filter, or it skips the filter. A pin that filters its input uses one of three shared cycle-count timers. Any number of pins may use the same timer.

The filtered level can be read back in the pin's control word. This holds even while the pin drives, so the readback shows what the wire carries and not what was written. The written output bit reads back at once. Each pin can detect a rising edge, a falling edge, both edges, a high level or a low level. A detected event sets a sticky status bit. Software clears that bit by writing a one to it. One word at a fixed address gathers all status bits. A single interrupt line goes high while any pin has both its status bit and its enable bit set.

Top module: `gpio_bank_dbt`

## Requirements
- R1: After reset every control word reads zero apart from the live input bit, all three timers read zero, the status word reads zero, no pin drives and the interrupt line is low.
- R2: The control word at byte address 0x180 + 4*pin stores its fields in these bits: 0 output level, 1 drive enable (1 = drive), 2 interrupt enable, 3/4/5 trigger bits A/B/C, 6 keep-through-reset flag, 7/8 filter select high/low, 9 event mask. A write takes effect on the next clock edge. It shows at once on pin_out and pin_oe and in the readback of bits 0 to 9. Writing bit 13 has no effect.
- R3: Bit 13 of a control word returns the filtered pin level, even when the pin drives. With the filter off, a pin change appears there three clock edges after it reaches pin_in.
- R4: The three timer registers sit at byte addresses 0x000, 0x004 and 0x008. Each holds a period of CNT_W bits counted in clock cycles, and wider write data is cut to that width.
- R5: The filter select code {bit7, bit8} picks the filter: 00 means none, 01 uses timer 0, 10 uses timer 1 and 11 uses timer 2.
- R6: With a timer of period N selected, the filtered level takes a new value only after the synchronized input has held that value for max(N,1) consecutive cycles. It changes 2+max(N,1) edges after the pin does. Any return to the old value restarts the count.
- R7: With trigger bits C=0 and A=0, B=1 detects a rising edge and B=0 detects a falling edge of the filtered level. The status bit sets one edge after the filtered level changes.
- R8: With trigger bit C=1, both edges are detected.
- R9: With C=0 and A=1, B=1 detects a high level and B=0 detects a low level. The status bit stays set during a clear while the level persists.
- R10: Writing a control word with bit 12 set clears that pin's status bit, and with bit 12 clear it leaves the bit alone. The word at 0x100 shows the status of pin i in bit i.
- R11: irq is high exactly when some pin has both its status bit and its interrupt enable set. A status bit sets whatever the enable is.
- R12: With the event mask bit 9 set, the pin's status bit is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Levels seen on the pins |
| pin_out | output | NUM_PINS | Output level per pin |
| pin_oe | output | NUM_PINS | Drive enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Pins are tried with four filter settings. These are no filter and timers of 2, 5 and 9 cycles. The exact edge on which the filtered level flips shows whether the right timer was picked and whether the hold count is off by one. A pulse shorter than the period, and a burst of pulses, show whether the count restarts on a bounce. The trigger tests run a rising step and a falling step under each of the five trigger modes. They also clear the status while a level is still present. This separates edge detection from level detection and shows that a set wins over a clear in the same cycle. Masked pins and pins with the enable off separate the status bit from the interrupt line.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Per-pin configuration; packing order matches control word bits 9..0
  typedef struct packed {
    logic ev_mask;   // bit 9
    logic flt_lo;    // bit 8
    logic flt_hi;    // bit 7
    logic keep_rst;  // bit 6
    logic trig_c;    // bit 5
    logic trig_b;    // bit 4
    logic trig_a;    // bit 3
    logic irq_en;    // bit 2
    logic drive;     // bit 1
    logic dout;      // bit 0
  } pin_cfg_t;

  localparam int CFG_W     = $bits(pin_cfg_t);
  localparam int CLR_BIT   = 12;
  localparam int NUM_TMR   = 3;
  localparam int STS_BASE  = 'h100;
  localparam int CTRL_BASE = 'h180;

  // Filter select code: 0 = bypass, k = timer k-1
  function automatic logic [1:0] flt_code(pin_cfg_t c);
    return {c.flt_hi, c.flt_lo};
  endfunction

  // Event decision from the filtered level now and one cycle ago
  function automatic logic trig_hit(pin_cfg_t c, logic now_v, logic was_v);
    if (c.trig_c)  return now_v ^ was_v;
    if (!c.trig_a) return c.trig_b ? (now_v & ~was_v) : (~now_v & was_v);
    return c.trig_b ? now_v : ~now_v;
  endfunction

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 16,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output pin_cfg_t          cfg [NUM_PINS],
  output logic [CNT_W-1:0]  tmr [NUM_TMR],
  output logic [NUM_PINS-1:0] sts_clr,
  output logic              a_ctrl,
  output logic              a_sts,
  output logic              a_tmr,
  output logic [1:0]        a_tmr_idx,
  output logic [PIN_W-1:0]  a_pin
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] STS_A  = ADDR_W'(STS_BASE);
  localparam logic [ADDR_W-3:0] NPIN_W = (ADDR_W-2)'(NUM_PINS);

  logic [ADDR_W-3:0] ctrl_word;
  wire unused_wd = ^bus_wdata;

  always_comb begin
    ctrl_word = bus_addr[ADDR_W-1:2] - CTRL_A[ADDR_W-1:2];
    a_ctrl    = (bus_addr[1:0] == 2'b00) && (bus_addr >= CTRL_A) && (ctrl_word < NPIN_W);
    a_pin     = ctrl_word[PIN_W-1:0];
    a_sts     = (bus_addr == STS_A);
    a_tmr     = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0) &&
                (bus_addr[3:2] != 2'b11);
    a_tmr_idx = bus_addr[3:2];
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      sts_clr[i] = bus_wr && a_ctrl && (a_pin == PIN_W'(i)) && bus_wdata[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) cfg[i] <= '0;
      for (int j = 0; j < NUM_TMR; j++)  tmr[j] <= '0;
    end else if (bus_wr) begin
      for (int i = 0; i < NUM_PINS; i++)
        if (a_ctrl && a_pin == PIN_W'(i)) cfg[i] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
      for (int j = 0; j < NUM_TMR; j++)
        if (a_tmr && a_tmr_idx == 2'(j)) tmr[j] <= bus_wdata[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/gpio_dbnc_filter.sv
module gpio_dbnc_filter
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  pin_cfg_t            cfg [NUM_PINS],
  input  logic [CNT_W-1:0]    tmr [NUM_TMR],
  output logic [NUM_PINS-1:0] sync_lvl,
  output logic [NUM_PINS-1:0] filt
);

  // True once the count, including this cycle, reaches the period
  function automatic logic held_enough(logic [CNT_W-1:0] c, logic [CNT_W-1:0] n);
    return ({1'b0, c} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, n};
  endfunction

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic             s1_q, s2_q, f_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       code;
    logic [CNT_W-1:0] need;

    always_comb begin
      code = flt_code(cfg[i]);
      need = (code == 2'b00) ? '0 : tmr[code - 2'd1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        f_q   <= 1'b0;
        cnt_q <= '0;
      end else begin
        s1_q <= pin_in[i];
        s2_q <= s1_q;
        if (s2_q == f_q) begin
          cnt_q <= '0;
        end else if (held_enough(cnt_q, need)) begin
          f_q   <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign sync_lvl[i] = s2_q;
    assign filt[i]     = f_q;
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] filt,
  input  pin_cfg_t            cfg [NUM_PINS],
  input  logic [NUM_PINS-1:0] sts_clr,
  output logic [NUM_PINS-1:0] ev,
  output logic [NUM_PINS-1:0] sts
);

  logic [NUM_PINS-1:0] filt_d;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      ev[i] = trig_hit(cfg[i], filt[i], filt_d[i]) & ~cfg[i].ev_mask;
  end

  // A new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_d <= '0;
      sts    <= '0;
    end else begin
      filt_d <= filt;
      sts    <= (sts & ~sts_clr) | ev;
    end
  end

endmodule

// File: rtl/gpio_bank_dbt.sv
module gpio_bank_dbt
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  pin_cfg_t            cfg [NUM_PINS];
  logic [CNT_W-1:0]    tmr [NUM_TMR];
  logic [NUM_PINS-1:0] sts_clr, sync_lvl, filt, ev, sts, ie_vec;
  logic                a_ctrl, a_sts, a_tmr;
  logic [1:0]          a_tmr_idx;
  logic [PIN_W-1:0]    a_pin;

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cfg(cfg), .tmr(tmr), .sts_clr(sts_clr),
    .a_ctrl(a_ctrl), .a_sts(a_sts), .a_tmr(a_tmr), .a_tmr_idx(a_tmr_idx),
    .a_pin(a_pin)
  );

  gpio_dbnc_filter #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) filt_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg(cfg), .tmr(tmr),
    .sync_lvl(sync_lvl), .filt(filt)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) stat_i (
    .clk(clk), .rst_n(rst_n), .filt(filt), .cfg(cfg), .sts_clr(sts_clr),
    .ev(ev), .sts(sts)
  );

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      pin_out[i] = cfg[i].dout;
      pin_oe[i]  = cfg[i].drive;
      ie_vec[i]  = cfg[i].irq_en;
    end
  end

  assign irq = |(sts & ie_vec);

  always_comb begin
    bus_rdata = '0;
    if (a_tmr)
      bus_rdata = 32'(tmr[a_tmr_idx]);
    else if (a_sts)
      bus_rdata = 32'(sts);
    else if (a_ctrl)
      bus_rdata = {18'b0, filt[a_pin], sts[a_pin], 2'b00, cfg[a_pin]};
  end

endmodule

// File: rtl/gpio_bank_dbt_chk.sv
module gpio_bank_dbt_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] sync_lvl,
  input logic [NUM_PINS-1:0] filt,
  input logic [NUM_PINS-1:0] ev,
  input logic [NUM_PINS-1:0] sts,
  input logic [NUM_PINS-1:0] sts_clr
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && irq == 1'b0));

  p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  p_filter_takes_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt ^ $past(filt)) & (filt ^ $past(sync_lvl))) == '0));

  p_set_needs_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(ev)) == '0));

  p_clear_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(sts_clr & ~ev)) == '0));

  p_drop_needs_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts) & ~sts & ~$past(sts_clr)) == '0));

  p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0));

endmodule

bind gpio_bank_dbt gpio_bank_dbt_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .sync_lvl(sync_lvl), .filt(filt), .ev(ev), .sts(sts), .sts_clr(sts_clr)
);

// File: tb/gpio_bank_dbt_tb_top.sv
module gpio_bank_dbt_tb_top;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [NP-1:0] pin_in = '0;
  wire  [31:0]   bus_rdata;
  wire  [NP-1:0] pin_out, pin_oe;
  wire           irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_bank_dbt dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit         ms1[NP], ms2[NP], mf[NP], mfd[NP], msts[NP];
  int         mcnt[NP];
  logic [9:0] mcfg[NP];
  int         mtmr[3];

  function automatic logic [31:0] exp_rd(logic [9:0] a);
    logic [31:0] v;
    int p;
    v = '0;
    if (a == 10'h000 || a == 10'h004 || a == 10'h008) v = 32'(mtmr[a / 4]);
    else if (a == 10'h100) begin
      for (int i = 0; i < NP; i++) v[i] = msts[i];
    end else if (a >= 10'h180 && a < 10'h200 && a[1:0] == 2'b00) begin
      p = (int'(a) - 'h180) / 4;
      v = {18'b0, mf[p], msts[p], 2'b00, mcfg[p]};
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        ms1[i] = 0; ms2[i] = 0; mf[i] = 0; mfd[i] = 0; msts[i] = 0;
        mcnt[i] = 0; mcfg[i] = '0;
      end
      for (int k = 0; k < 3; k++) mtmr[k] = 0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        bit hit, clr;
        int code, need;
        if (mcfg[i][5])       hit = (mf[i] != mfd[i]);
        else if (!mcfg[i][3]) hit = mcfg[i][4] ? (mf[i] && !mfd[i]) : (!mf[i] && mfd[i]);
        else                  hit = mcfg[i][4] ? mf[i] : !mf[i];
        if (mcfg[i][9]) hit = 0;
        clr = bus_wr && (int'(bus_addr) == 'h180 + 4 * i) && bus_wdata[12];
        msts[i] = (msts[i] && !clr) || hit;
        mfd[i] = mf[i];
        code = 2 * int'(mcfg[i][7]) + int'(mcfg[i][8]);
        need = (code == 0) ? 1 : ((mtmr[code - 1] < 1) ? 1 : mtmr[code - 1]);
        if (ms2[i] == mf[i]) mcnt[i] = 0;
        else if (mcnt[i] + 1 >= need) begin mf[i] = ms2[i]; mcnt[i] = 0; end
        else mcnt[i] = mcnt[i] + 1;
        ms2[i] = ms1[i];
        ms1[i] = pin_in[i];
      end
      if (bus_wr) begin
        if (bus_addr == 10'h000 || bus_addr == 10'h004 || bus_addr == 10'h008)
          mtmr[bus_addr / 4] = int'(bus_wdata[15:0]);
        else if (bus_addr >= 10'h180 && bus_addr < 10'h200 && bus_addr[1:0] == 2'b00)
          mcfg[(int'(bus_addr) - 'h180) / 4] = bus_wdata[9:0];
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      logic [NP-1:0] eo, ee;
      logic ei;
      ei = 0;
      for (int i = 0; i < NP; i++) begin
        eo[i] = mcfg[i][0];
        ee[i] = mcfg[i][1];
        if (msts[i] && mcfg[i][2]) ei = 1;
      end
      check("R2 pin_out", 32'(pin_out), 32'(eo));
      check("R2 pin_oe", 32'(pin_oe), 32'(ee));
      check("R11 irq", 32'(irq), 32'(ei));
      check("R3 readback", bus_rdata, exp_rd(bus_addr));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [9:0] ctl(int p);
    return 10'('h180 + 4 * p);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_bit(string tag, logic [9:0] a, int b, logic e);
    logic [31:0] d;
    rd(a, d);
    check(tag, 32'(d[b]), 32'(e));
  endtask

  // filter latency: drive high, expect flip exactly 2+N edges later
  task automatic latency(int p, int n, string tag);
    pin_in[p] = 1'b1;
    tick(1 + n);
    chk_bit(tag, ctl(p), 13, 1'b0);
    tick(1);
    chk_bit(tag, ctl(p), 13, 1'b1);
    pin_in[p] = 1'b0;
    tick(n + 4);
  endtask

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(ctl(0), d);  check("R1 ctrl0", d, 32'h0);
    rd(ctl(31), d); check("R1 ctrl31", d, 32'h0);
    rd(10'h004, d); check("R1 timer1", d, 32'h0);
    rd(10'h100, d); check("R1 status", d, 32'h0);
    check("R1 oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 field storage and immediate latch readback
    wr(ctl(5), 32'h0000_0003);
    check("R2 out5", 32'(pin_out[5]), 32'h1);
    check("R2 oe5", 32'(pin_oe[5]), 32'h1);
    chk_bit("R2 latch bit0", ctl(5), 0, 1'b1);
    wr(ctl(7), 32'h0000_22AA);   // bit 13 set in the write is ignored
    rd(ctl(7), d); check("R2 fields pin7", d, 32'h0000_02AA);
    wr(ctl(7), 32'h0);

    // R3 input readback while driving, three edges of delay
    pin_in[5] = 1'b1;
    tick(2);
    chk_bit("R3 not yet", ctl(5), 13, 1'b0);
    tick(1);
    chk_bit("R3 seen", ctl(5), 13, 1'b1);
    chk_bit("R3 latch kept", ctl(5), 0, 1'b1);

    // R4 timers
    wr(10'h000, 32'd2);
    wr(10'h004, 32'd5);
    wr(10'h008, 32'h0001_2345);
    rd(10'h008, d); check("R4 truncate", d, 32'h0000_2345);
    wr(10'h008, 32'd9);
    rd(10'h000, d); check("R4 timer0", d, 32'd2);
    rd(10'h004, d); check("R4 timer1", d, 32'd5);

    // R5 / R6 select codes and hold lengths
    wr(ctl(16), 32'h000);  latency(16, 1, "R5 code00");
    wr(ctl(9),  32'h100);  latency(9, 2, "R5 code01 timer0");
    wr(ctl(10), 32'h080);  latency(10, 5, "R6 code10 timer1");
    wr(ctl(11), 32'h180);  latency(11, 9, "R6 code11 timer2");

    // R6 bounce restarts the count
    pin_in[10] = 1'b1; tick(3); pin_in[10] = 1'b0; tick(1);
    pin_in[10] = 1'b1; tick(4); pin_in[10] = 1'b0;
    tick(12);
    chk_bit("R6 bounce rejected", ctl(10), 13, 1'b0);

    // R7 rising edge with enable
    wr(ctl(12), 32'h014);
    pin_in[12] = 1'b1;
    tick(3);
    chk_bit("R7 rise early", 10'h100, 12, 1'b0);
    tick(1);
    chk_bit("R7 rise set", 10'h100, 12, 1'b1);
    check("R11 irq on", 32'(irq), 32'h1);
    wr(ctl(12), 32'h1014);
    chk_bit("R10 w1c", 10'h100, 12, 1'b0);
    check("R11 irq off", 32'(irq), 32'h0);
    pin_in[12] = 1'b0;
    tick(6);
    chk_bit("R7 fall ignored", 10'h100, 12, 1'b0);

    // R7 falling edge
    pin_in[17] = 1'b1; tick(6);
    wr(ctl(17), 32'h004);
    pin_in[17] = 1'b0;
    tick(3);
    chk_bit("R7 fall early", 10'h100, 17, 1'b0);
    tick(1);
    chk_bit("R7 fall set", 10'h100, 17, 1'b1);
    wr(ctl(17), 32'h0000);   // bit 12 clear: status kept
    chk_bit("R10 write zero keeps", 10'h100, 17, 1'b1);
    wr(ctl(17), 32'h1000);

    // R8 both edges
    wr(ctl(13), 32'h020);
    pin_in[13] = 1'b1; tick(5);
    chk_bit("R8 rise", 10'h100, 13, 1'b1);
    wr(ctl(13), 32'h1020);
    chk_bit("R8 cleared", 10'h100, 13, 1'b0);
    pin_in[13] = 1'b0; tick(5);
    chk_bit("R8 fall", 10'h100, 13, 1'b1);

    // R9 level high, persists through clear
    wr(ctl(14), 32'h018);
    pin_in[14] = 1'b1; tick(5);
    chk_bit("R9 high set", 10'h100, 14, 1'b1);
    wr(ctl(14), 32'h1018);
    chk_bit("R9 re-assert", 10'h100, 14, 1'b1);
    check("R11 no enable", 32'(irq), 32'h0);
    wr(ctl(14), 32'h01C);
    check("R11 enable on", 32'(irq), 32'h1);
    pin_in[14] = 1'b0; tick(5);
    wr(ctl(14), 32'h101C);
    chk_bit("R9 level gone", 10'h100, 14, 1'b0);
    check("R11 back low", 32'(irq), 32'h0);

    // R9 level low: pin already low
    wr(ctl(18), 32'h008);
    tick(1);
    chk_bit("R9 low set", 10'h100, 18, 1'b1);

    // R12 mask
    wr(ctl(15), 32'h210);
    pin_in[15] = 1'b1; tick(6);
    chk_bit("R12 masked", 10'h100, 15, 1'b0);
    chk_bit("R12 level seen", ctl(15), 13, 1'b1);

    // R10 status word shows several pins
    rd(10'h100, d);
    check("R10 multi", 32'(d[18] & d[13] & ~d[12] & ~d[15]), 32'h1);

    tick(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule